// File: doc/BRIEF.md
# Source-Address Learning Forwarding Table

This block is the forwarding table that sits beside one egress port of a small Ethernet switch. Every ingress port feeds it a stream of source MAC addresses taken from received frames. The table remembers each address together with the index of the port it arrived on. When the egress side needs to route a frame, it presents the destination MAC on a lookup port. One cycle later it gets back a one-hot mask naming the port where that address was most recently seen.

A lookup that finds nothing returns a flood mask: every port except the one this table belongs to (`SELF_PORT`). Two configuration masks adjust the behaviour:

- A "never" mask silences ingress ports. Their insert streams are still drained, but they teach the table nothing.
- An "always" mask names ports that are added to every lookup result.

The own-port bit is removed from every result last, so a frame is never reflected back where it came from. Entries that are not refreshed for about 2^`LG_AGE` cycles expire. When the table is full, a new address replaces the oldest entry.

Insert streams that are valid in the same cycle are served one per cycle by a round-robin arbiter. A lookup sees the table as it stood before any insert accepted in the same cycle.

Top module: `mactbl_learn`

## Requirements
- R1: After a synchronous reset the table is empty: `fill` is 0, `lk_ack` is 0 and `lk_mask` is 0. With no insert valid and no port silenced, every `ins_ready` bit is 0.
- R2: When an insert of an unknown address is accepted (valid and ready high at a clock edge), a new entry holding that address and the ingress port index is created. `fill` rises by exactly one, and it never rises by more than one per cycle.
- R3: An accepted insert of an address already held updates that entry's port and restarts its age. No entry is allocated and `fill` is unchanged.
- R4: A lookup of an address not held returns the flood mask, in which bit i stands for port i: all ports except `SELF_PORT`.
- R5: Bit `SELF_PORT` of `lk_mask` is 0 in every acknowledged result, including a hit on an address learned from `SELF_PORT`, which then yields mask 0 (before the always mask).
- R6: The result equals (hit one-hot or flood mask) OR the `cfg_always` sampled with the request, then with bit `SELF_PORT` cleared.
- R7: A port whose `cfg_never` bit is 1 sees `ins_ready` high whenever it is valid, and its addresses are neither learned nor used to update entries.
- R8: Among the valid, non-silenced insert streams at most one sees `ins_ready` high per cycle. The grant rotates round-robin starting after the last granted port, and port 0 is first after reset.
- R9: `lk_ack` is 1 in the cycle after each cycle with `lk_req` high, and 0 in the cycle after a cycle with `lk_req` low.
- R10: An entry that is not refreshed by an insert for 2^`LG_AGE` cycles is removed: lookups miss and `fill` drops. An insert of the same address restarts the count.
- R11: When all 2^`LG_DEPTH` entries are valid, an unknown address replaces the entry with the greatest age (lowest index on a tie), and `fill` stays at full. Otherwise, the lowest-index free entry is used.
- R12: `fill` equals the number of valid entries and never exceeds 2^`LG_DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | NPORT | Per-port insert request |
| ins_ready | output | NPORT | Per-port insert accept |
| ins_mac | input | NPORT*MACW | Source address per port, port i in bits i*MACW upward |
| cfg_never | input | NPORT | Ports whose inserts are discarded |
| cfg_always | input | NPORT | Ports added to every lookup result |
| lk_req | input | 1 | Lookup request |
| lk_mac | input | MACW | Destination address to look up |
| lk_ack | output | 1 | Result valid, one cycle after the request |
| lk_mask | output | NPORT | One-hot or flood destination mask |
| fill | output | LG_DEPTH+1 | Number of valid entries |

## Verification
The following are checked by the bound assertions on every cycle:
- the acknowledge timing;
- that the own-port bit never appears in a result;
- that the always ports are present;
- that at most one non-silenced stream is granted;
- that silenced streams are drained;
- that `fill` stays within bounds and climbs by at most one per cycle.

Some properties can only be shown by the bench's scenarios, because they need memory of earlier inserts: that a hit names the port where an address was last seen, that a moved address follows its new port, that the oldest entry is the one evicted when full, the order of the round-robin rotation, and that an unrefreshed entry disappears while a refreshed one stays.

// File: rtl/mactbl_pkg.sv
package mactbl_pkg;
    // Default sizing shared by the table and its checker.
    localparam int MT_NPORT    = 4;
    localparam int MT_MACW     = 48;
    localparam int MT_LG_DEPTH = 3;
    localparam int MT_LG_AGE   = 20;

    // Outcome of the associative search on the lookup side.
    typedef enum logic {
        LK_MISS = 1'b0,
        LK_HIT  = 1'b1
    } lk_kind_e;
endpackage

// File: rtl/mactbl_rr_arb.sv
// Round-robin grant among insert requests; priority starts after the last winner.
module mactbl_rr_arb #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);
    logic [IW-1:0] last_d, last_q;

    always_comb begin
        int c;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            c = (int'(last_q) + 1 + i) % N;
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(c);
                gnt[c]  = 1'b1;
            end
        end
        last_d = gnt_any ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= IW'(N - 1);
        else     last_q <= last_d;
    end
endmodule

// File: rtl/mactbl_victim.sv
// Picks the entry an unknown address will occupy: first free slot, else the oldest.
module mactbl_victim #(
    parameter int DEPTH    = 8,
    parameter int LG_DEPTH = 3,
    parameter int AW       = 20
) (
    input  logic [DEPTH-1:0]    vld,
    input  logic [DEPTH*AW-1:0] ages,
    output logic [LG_DEPTH-1:0] idx
);
    always_comb begin
        logic          have_free;
        logic [AW-1:0] best;
        have_free = 1'b0;
        idx       = '0;
        best      = ages[0 +: AW];
        for (int e = 0; e < DEPTH; e++) begin
            if (!vld[e] && !have_free) begin
                have_free = 1'b1;
                idx       = LG_DEPTH'(e);
            end
        end
        if (!have_free) begin
            for (int e = 1; e < DEPTH; e++) begin
                if (ages[e*AW +: AW] > best) begin
                    best = ages[e*AW +: AW];
                    idx  = LG_DEPTH'(e);
                end
            end
        end
    end
endmodule

// File: rtl/mactbl_learn.sv
module mactbl_learn
    import mactbl_pkg::*;
#(
    parameter int NPORT     = MT_NPORT,
    parameter int MACW      = MT_MACW,
    parameter int LG_DEPTH  = MT_LG_DEPTH,
    parameter int LG_AGE    = MT_LG_AGE,
    parameter int SELF_PORT = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT-1:0]      ins_valid,
    output logic [NPORT-1:0]      ins_ready,
    input  logic [NPORT*MACW-1:0] ins_mac,
    input  logic [NPORT-1:0]      cfg_never,
    input  logic [NPORT-1:0]      cfg_always,
    input  logic                  lk_req,
    input  logic [MACW-1:0]       lk_mac,
    output logic                  lk_ack,
    output logic [NPORT-1:0]      lk_mask,
    output logic [LG_DEPTH:0]     fill
);
    localparam int DEPTH = 1 << LG_DEPTH;
    localparam int PW    = $clog2(NPORT);
    localparam logic [LG_AGE-1:0] AGE_MAX  = '1;
    localparam logic [NPORT-1:0]  SELF_BIT = {{(NPORT-1){1'b0}}, 1'b1} << SELF_PORT;

    typedef struct packed {
        logic              vld;
        logic [MACW-1:0]   mac;
        logic [PW-1:0]     port;
        logic [LG_AGE-1:0] age;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic               ack;
        logic [NPORT-1:0]   mask;
    } state_t;

    state_t st_d, st_q;

    // Insert arbitration: silenced ports are drained without competing.
    logic [NPORT-1:0] gnt;
    logic [PW-1:0]    gnt_idx;
    logic             gnt_any;
    logic [MACW-1:0]  sel_mac;

    mactbl_rr_arb #(.N(NPORT), .IW(PW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (ins_valid & ~cfg_never),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign ins_ready = gnt | cfg_never;
    assign sel_mac   = ins_mac[int'(gnt_idx)*MACW +: MACW];

    // Per-entry comparators for both the insert and the lookup side.
    logic [DEPTH-1:0]        ins_hit, lk_hit, vld_vec;
    logic [DEPTH*LG_AGE-1:0] ages_flat;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign vld_vec[e]                   = st_q.ent[e].vld;
        assign ages_flat[e*LG_AGE +: LG_AGE] = st_q.ent[e].age;
        assign ins_hit[e] = st_q.ent[e].vld && (st_q.ent[e].mac == sel_mac);
        assign lk_hit[e]  = st_q.ent[e].vld && (st_q.ent[e].mac == lk_mac);
    end

    logic [LG_DEPTH-1:0] victim;

    mactbl_victim #(.DEPTH(DEPTH), .LG_DEPTH(LG_DEPTH), .AW(LG_AGE)) u_victim (
        .vld  (vld_vec),
        .ages (ages_flat),
        .idx  (victim)
    );

    lk_kind_e            lk_kind;
    logic [NPORT-1:0]    hit_mask, base_mask;
    logic [LG_DEPTH-1:0] tgt;
    logic [LG_DEPTH:0]   cnt;

    always_comb begin
        st_d     = st_q;
        hit_mask = '0;
        tgt      = victim;
        cnt      = '0;

        // Aging: an entry whose counter is saturated expires on this edge.
        for (int e = 0; e < DEPTH; e++) begin
            if (st_q.ent[e].vld) begin
                if (st_q.ent[e].age == AGE_MAX) st_d.ent[e].vld = 1'b0;
                else st_d.ent[e].age = st_q.ent[e].age + LG_AGE'(1);
            end
            if (ins_hit[e]) tgt = LG_DEPTH'(e);
            if (lk_hit[e])  hit_mask[st_q.ent[e].port] = 1'b1;
            cnt = cnt + (LG_DEPTH+1)'(st_q.ent[e].vld);
        end

        // Learn or refresh: a known address is rewritten in place.
        if (gnt_any) begin
            st_d.ent[tgt].vld  = 1'b1;
            st_d.ent[tgt].mac  = sel_mac;
            st_d.ent[tgt].port = gnt_idx;
            st_d.ent[tgt].age  = '0;
        end

        lk_kind   = (|lk_hit) ? LK_HIT : LK_MISS;
        base_mask = (lk_kind == LK_HIT) ? hit_mask : ~SELF_BIT;
        st_d.ack  = lk_req;
        st_d.mask = lk_req ? ((base_mask | cfg_always) & ~SELF_BIT) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lk_ack  = st_q.ack;
    assign lk_mask = st_q.mask;
    assign fill    = cnt;
endmodule

// File: rtl/mactbl_learn_chk.sv
module mactbl_learn_chk #(
    parameter int NPORT     = 4,
    parameter int LG_DEPTH  = 3,
    parameter int SELF_PORT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [NPORT-1:0]  ins_valid,
    input logic [NPORT-1:0]  ins_ready,
    input logic [NPORT-1:0]  cfg_never,
    input logic [NPORT-1:0]  cfg_always,
    input logic              lk_req,
    input logic              lk_ack,
    input logic [NPORT-1:0]  lk_mask,
    input logic [LG_DEPTH:0] fill
);
    localparam int DEPTH = 1 << LG_DEPTH;
    localparam logic [NPORT-1:0] SELF_BIT = {{(NPORT-1){1'b0}}, 1'b1} << SELF_PORT;

    // R9
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_ack);
    // R9
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !lk_ack);
    // R5
    no_reflect_chk: assert property (@(posedge clk) disable iff (rst)
        lk_ack |-> !lk_mask[SELF_PORT]);
    // R6
    always_ports_chk: assert property (@(posedge clk) disable iff (rst)
        lk_ack |-> ((lk_mask & $past(cfg_always) & ~SELF_BIT) == ($past(cfg_always) & ~SELF_BIT)));
    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ins_ready & ins_valid & ~cfg_never));
    // R7
    drain_silenced_chk: assert property (@(posedge clk) disable iff (rst)
        ((ins_valid & cfg_never & ~ins_ready) == '0));
    // R12
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);
    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= int'($past(fill)) + 1);
endmodule

bind mactbl_learn mactbl_learn_chk #(
    .NPORT(NPORT), .LG_DEPTH(LG_DEPTH), .SELF_PORT(SELF_PORT)
) u_chk (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .cfg_never(cfg_never), .cfg_always(cfg_always), .lk_req(lk_req),
    .lk_ack(lk_ack), .lk_mask(lk_mask), .fill(fill)
);

// File: tb/tb_mactbl_learn.sv
module tb_mactbl_learn;
    localparam int NP = 4;
    localparam int MW = 48;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] ins_valid, ins_ready, cfg_never, cfg_always, lk_mask;
    logic [NP*MW-1:0] ins_mac;
    logic          lk_req, lk_ack;
    logic [MW-1:0] lk_mac;
    logic [3:0]    fill;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    mactbl_learn #(.NPORT(NP), .MACW(MW), .LG_DEPTH(3), .LG_AGE(7), .SELF_PORT(0)) dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_mac(ins_mac), .cfg_never(cfg_never), .cfg_always(cfg_always),
        .lk_req(lk_req), .lk_mac(lk_mac), .lk_ack(lk_ack), .lk_mask(lk_mask),
        .fill(fill)
    );

    localparam logic [MW-1:0] MA = 48'h02_11_22_33_44_0A;
    localparam logic [MW-1:0] MB = 48'h02_11_22_33_44_0B;
    localparam logic [MW-1:0] MC = 48'h02_11_22_33_44_0C;
    localparam logic [MW-1:0] MD = 48'h02_11_22_33_44_0D;

    typedef struct packed {
        logic          lookup;
        logic [1:0]    port;
        logic [MW-1:0] mac;
        logic [3:0]    mask;
        logic [3:0]    fill;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, MA, 4'b1110, 4'd0},   // miss on empty table
        '{1'b0, 2'd2, MA, 4'b0000, 4'd1},   // learn A on port 2
        '{1'b1, 2'd0, MA, 4'b0100, 4'd1},
        '{1'b0, 2'd3, MB, 4'b0000, 4'd2},   // learn B on port 3
        '{1'b1, 2'd0, MB, 4'b1000, 4'd2},
        '{1'b0, 2'd1, MA, 4'b0000, 4'd2},   // A moves to port 1
        '{1'b1, 2'd0, MA, 4'b0010, 4'd2},
        '{1'b0, 2'd0, MC, 4'b0000, 4'd3},   // C learned on own port
        '{1'b1, 2'd0, MC, 4'b0000, 4'd3},
        '{1'b1, 2'd0, MD, 4'b1110, 4'd3}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ins_valid = '0; ins_mac = '0; cfg_never = '0; cfg_always = '0;
        lk_req = 1'b0; lk_mac = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ins(input int p, input logic [MW-1:0] m);
        @(negedge clk);
        ins_mac[p*MW +: MW] = m;
        ins_valid[p] = 1'b1;
        #1;
        while (!ins_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        ins_valid[p] = 1'b0;
    endtask

    task automatic lookup(input logic [MW-1:0] m, output logic [3:0] mk, output logic ak);
        @(negedge clk);
        lk_req = 1'b1;
        lk_mac = m;
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        mk = lk_mask;
        ak = lk_ack;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] mk;
        logic       ak;
        rst = 1'b1;
        do_reset();

        // R1: empty state after reset
        chk("R1 fill", 64'(fill), 64'd0);
        chk("R1 ack", 64'(lk_ack), 64'd0);
        chk("R1 mask", 64'(lk_mask), 64'd0);
        chk("R1 ready", 64'(ins_ready), 64'd0);

        // Vector walk: R2 learn, R3 move, R4 miss, R5 own-port hit
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].lookup) begin
                lookup(VEC[i].mac, mk, ak);
                chk($sformatf("R9 ack vec %0d", i), 64'(ak), 64'd1);
                chk($sformatf("R2 R3 R4 R5 mask vec %0d", i), 64'(mk), 64'(VEC[i].mask));
            end else begin
                ins(int'(VEC[i].port), VEC[i].mac);
            end
            chk($sformatf("R2 R3 R12 fill vec %0d", i), 64'(fill), 64'(VEC[i].fill));
        end
        @(negedge clk);
        chk("R9 ack drops", 64'(lk_ack), 64'd0);

        // R6: always ports OR-ed in, own bit cleared even if named
        @(negedge clk);
        cfg_always = 4'b0011;
        lookup(MD, mk, ak);
        chk("R6 miss with always", 64'(mk), 64'b1110);
        lookup(MB, mk, ak);
        chk("R6 hit with always", 64'(mk), 64'b1010);
        cfg_always = '0;

        // R7: silenced port drained but not learned
        do_reset();
        @(negedge clk);
        cfg_never = 4'b0100;
        ins_mac[2*MW +: MW] = MA;
        ins_valid[2] = 1'b1;
        #1;
        chk("R7 drained", 64'(ins_ready[2]), 64'd1);
        @(posedge clk);
        @(negedge clk);
        ins_valid[2] = 1'b0;
        chk("R7 not learned fill", 64'(fill), 64'd0);
        lookup(MA, mk, ak);
        chk("R7 not learned lookup", 64'(mk), 64'b1110);
        cfg_never = '0;

        // R8: round-robin order from reset
        do_reset();
        @(negedge clk);
        for (int p = 0; p < NP; p++) ins_mac[p*MW +: MW] = MA + 48'(p);
        ins_valid = '1;
        for (int k = 0; k < NP; k++) begin
            #1;
            chk($sformatf("R8 first rotation %0d", k), 64'(ins_ready), 64'(4'b0001 << k));
            @(posedge clk);
            @(negedge clk);
            ins_valid[k] = 1'b0;
        end
        chk("R8 fill after four", 64'(fill), 64'd4);
        ins_valid = 4'b0011;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk($sformatf("R8 alternation %0d", k), 64'(ins_ready), (k % 2 == 0) ? 64'd1 : 64'd2);
            @(posedge clk);
            @(negedge clk);
        end
        ins_valid = '0;
        chk("R3 refresh keeps fill", 64'(fill), 64'd4);

        // R11: full table evicts the oldest entry
        do_reset();
        for (int i = 0; i < 8; i++) ins(1, 48'h0A00 + 48'(i));
        chk("R12 full", 64'(fill), 64'd8);
        ins(2, 48'h0BFF);
        chk("R11 fill stays full", 64'(fill), 64'd8);
        lookup(48'h0A00, mk, ak);
        chk("R11 oldest evicted", 64'(mk), 64'b1110);
        lookup(48'h0BFF, mk, ak);
        chk("R11 newcomer", 64'(mk), 64'b0100);
        lookup(48'h0A01, mk, ak);
        chk("R11 next oldest kept", 64'(mk), 64'b0010);

        // R10: aging with and without refresh (age limit 128 cycles here)
        do_reset();
        ins(3, MC);
        repeat (10) @(negedge clk);
        lookup(MC, mk, ak);
        chk("R10 young hit", 64'(mk), 64'b1000);
        repeat (50) @(negedge clk);
        ins(3, MC);
        repeat (100) @(negedge clk);
        lookup(MC, mk, ak);
        chk("R10 refreshed hit", 64'(mk), 64'b1000);
        repeat (150) @(negedge clk);
        lookup(MC, mk, ak);
        chk("R10 expired miss", 64'(mk), 64'b1110);
        chk("R10 expired fill", 64'(fill), 64'd0);

        summary();
        $finish;
    end
endmodule